// File: doc/BRIEF.md
# Runtime-Format Floating-Point Multiplier

This unit multiplies two 16-bit floating-point words. The split of each word between exponent and fraction is not fixed. A register holds the exponent width E, and the unit adjusts E itself as products come out. Operands are presented in the format currently in force. The result leaves in the format that was in force when it was computed, and the width that applies is reported beside it.

When a product falls outside the exponent range of the current format, the unit does three things before it delivers anything. It widens the exponent by one bit at the cost of one fraction bit. It re-encodes the two stored operands into the wider format. It then multiplies again. When a delivered product would also fit a format one exponent bit narrower, the unit narrows E for the operations that follow, which returns a bit to the fraction.

A valid/ready handshake on the input side covers the variable latency that retries cause. A saturating counter reports how many retries have happened since reset.

Top module: `remul_unit`

## Requirements
- R1: A word has the sign in bit 15, an exponent field of E bits in bits 14 down to 15-E, and a fraction of 15-E bits below it. Its value is (-1)^sign x 1.fraction x 2^(field - (2^(E-1) - 1)). A field of 0 means zero whatever the fraction bits hold. E always lies between 3 and 8 inclusive.
- R2: An in-range product is rounded to the current fraction width with round-to-nearest, ties-to-even. A rounding carry increments the exponent. The result is delivered with outExpW equal to the E it is encoded in, and with outSat low.
- R3: If the product's field would be above 2^E - 1 or below 1 while E < 8, E becomes E+1 and the stored operands are re-encoded. Re-encoding keeps the value of the exponent, drops the lowest fraction bit with ties-to-even rounding, and lets a rounding carry raise the exponent. The multiply is then redone. Only the final result is delivered, and each retry adds one cycle of latency.
- R4: At E = 8, an overflowing product is delivered as sign, an all-ones field and an all-ones fraction, with outSat high. An underflowing product is delivered as the sign bit followed by 15 zero bits, with outSat low.
- R5: After a nonzero, in-range product whose unbiased exponent u satisfies 2 - 2^(E-2) <= u <= 2^(E-2), E decreases by one if E > 3. The delivered result still uses the old E.
- R6: If either operand has a zero field, the result is the XOR of the signs in bit 15 with all other bits 0. No retry is made and E stays the same.
- R7: inReady is high only while the unit is idle. An operand pair is taken on a rising edge with inValid and inReady both high. The result's outValid pulse comes two edges after the accepting edge, plus one edge per retry, and lasts one cycle per product. While inReady is low, inValid and the operand inputs have no effect.
- R8: retryCount increments by one for each retry and holds at 65535 once it reaches it.
- R9: Reset is active low. It sets E to 5, inReady high, outValid low and retryCount to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair is present |
| inReady | output | 1 | Unit is idle and takes an operand pair |
| inA | input | 16 | First operand, current format |
| inB | input | 16 | Second operand, current format |
| outValid | output | 1 | One-cycle pulse marking a finished product |
| outWord | output | 16 | Product word |
| outExpW | output | 4 | Exponent width E of outWord |
| outSat | output | 1 | Product saturated at the widest format |
| retryCount | output | 16 | Saturating count of retries |

## Verification
The bench first drives E down to its floor by repeated unity products, which shows the narrowing rule and the report of the old width. A design that narrowed early would tag results with the wrong E and would go on to misread every later operand. It then climbs the width with maximum-exponent squares until E reaches 8. It uses fractions whose re-encoding rounds upward, so that a wrong ties-to-even rule or a lost exponent carry shows up as a wrong word or a missing second retry. At the widest format it checks both saturation and the flush to a signed zero: a design that kept retrying would hang or deliver out-of-format codes. It also holds junk operands on the inputs while the unit is busy, which would surface as extra or corrupted results if the busy window leaked.

// File: rtl/remul_pkg.sv
package remul_pkg;

  localparam int WORD_W = 16;
  localparam int BODY_W = WORD_W - 1;
  localparam int E_MIN  = 3;
  localparam int E_MAX  = 8;
  localparam int E_RST  = 5;
  localparam int EW     = $clog2(E_MAX + 2);
  localparam int MW_MAX = BODY_W - E_MIN;
  localparam int SIG_W  = MW_MAX + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int XW     = E_MAX + 3;
  localparam int CNT_W  = 16;
  localparam int LANES  = 2;

  typedef logic [EW-1:0] expWidthT;

  // unpacked operand: significand left-aligned with its hidden one at the MSB
  typedef struct packed {
    logic                 zero;
    logic                 sign;
    logic signed [XW-1:0] uexp;
    logic [SIG_W-1:0]     sig;
  } opT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic retry;
    logic finish;
  } strobeT;

  function automatic int biasOf(input int e);
    return (1 << (e - 1)) - 1;
  endfunction

  function automatic int maxFieldOf(input int e);
    return (1 << e) - 1;
  endfunction

  function automatic opT unpackWord(input logic [WORD_W-1:0] w, input int e);
    opT o;
    int mw;
    int field;
    logic [BODY_W-1:0] body;
    logic [BODY_W-1:0] frac;
    body  = w[BODY_W-1:0];
    mw    = BODY_W - e;
    field = int'((body >> mw) & BODY_W'((1 << e) - 1));
    frac  = body & BODY_W'((1 << mw) - 1);
    o.zero = (field == 0);
    o.sign = w[WORD_W-1];
    o.uexp = XW'(field - biasOf(e));
    o.sig  = SIG_W'(frac | BODY_W'(1 << mw)) << (MW_MAX - mw);
    return o;
  endfunction

  function automatic logic [WORD_W-1:0] packWord(input logic sign, input int field,
                                                 input int mant, input int e);
    int mw;
    mw = BODY_W - e;
    return {sign, BODY_W'((field << mw) | mant)};
  endfunction

  // drop the low 'drop' bits of v, rounding to nearest with ties to even
  function automatic logic [PROD_W-1:0] rneDrop(input logic [PROD_W-1:0] v, input int drop);
    logic [PROD_W-1:0] kept;
    logic [PROD_W-1:0] low;
    logic guardBit;
    logic stickyBit;
    kept = v >> drop;
    if (drop == 0) begin
      guardBit  = 1'b0;
      stickyBit = 1'b0;
    end else begin
      guardBit  = |(v & (PROD_W'(1) << (drop - 1)));
      low       = v & ((PROD_W'(1) << (drop - 1)) - PROD_W'(1));
      stickyBit = |low;
    end
    return kept + PROD_W'(guardBit & (stickyBit | kept[0]));
  endfunction

endpackage

// File: rtl/remul_reencode.sv
// Re-encodes one stored operand from width E into width E+1.
module remul_reencode
  import remul_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  expWidthT          curE,
  output logic [WORD_W-1:0] wideWord
);

  opT                op;
  logic [PROD_W-1:0] rnd;
  logic              carry;
  int                mw;
  int                uexp;
  int                mant;
  int                newE;

  always_comb begin
    op    = unpackWord(word, int'(curE));
    mw    = BODY_W - int'(curE);
    newE  = int'(curE) + 1;
    // keep the hidden one plus mw-1 fraction bits
    rnd   = rneDrop(PROD_W'(op.sig), SIG_W - mw);
    carry = (rnd == (PROD_W'(1) << mw));
    uexp  = int'($signed(op.uexp)) + (carry ? 1 : 0);
    mant  = carry ? 0 : int'(rnd & ((PROD_W'(1) << (mw - 1)) - PROD_W'(1)));
    if (op.zero) wideWord = {op.sign, BODY_W'(0)};
    else         wideWord = packWord(op.sign, uexp + biasOf(newE), mant, newE);
  end

endmodule

// File: rtl/remul_mulcore.sv
// Single-cycle multiply, normalise, round and range classification.
module remul_mulcore
  import remul_pkg::*;
(
  input  logic [WORD_W-1:0] wordA,
  input  logic [WORD_W-1:0] wordB,
  input  expWidthT          curE,
  output logic [WORD_W-1:0] prodWord,
  output logic              prodSign,
  output logic              ovf,
  output logic              unf,
  output logic              fitsNarrow
);

  opT                opA;
  opT                opB;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] norm;
  logic [PROD_W-1:0] rnd;
  logic              hi;
  logic              zero;
  logic              carry;
  int                eNow;
  int                mw;
  int                uexp;
  int                field;
  int                nField;
  int                mant;

  always_comb begin
    eNow     = int'(curE);
    opA      = unpackWord(wordA, eNow);
    opB      = unpackWord(wordB, eNow);
    mw       = BODY_W - eNow;
    zero     = opA.zero | opB.zero;
    prodSign = opA.sign ^ opB.sign;
    prod     = PROD_W'(opA.sig) * PROD_W'(opB.sig);
    hi       = prod[PROD_W-1];
    norm     = hi ? prod : (prod << 1);
    rnd      = rneDrop(norm, PROD_W - 1 - mw);
    carry    = (rnd == (PROD_W'(1) << (mw + 1)));
    uexp     = int'($signed(opA.uexp)) + int'($signed(opB.uexp))
             + (hi ? 1 : 0) + (carry ? 1 : 0);
    mant     = carry ? 0 : int'(rnd & ((PROD_W'(1) << mw) - PROD_W'(1)));
    field    = uexp + biasOf(eNow);
    nField   = uexp + biasOf(eNow - 1);
    ovf      = !zero && (field > maxFieldOf(eNow));
    unf      = !zero && (field < 1);
    fitsNarrow = !zero && !ovf && !unf && (eNow > E_MIN)
               && (nField >= 1) && (nField <= maxFieldOf(eNow - 1));
    if (zero) prodWord = {prodSign, BODY_W'(0)};
    else      prodWord = packWord(prodSign, field, mant, eNow);
  end

endmodule

// File: rtl/remul_datapath.sv
// Operand registers, re-encoders, multiply core and result register.
module remul_datapath
  import remul_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inA,
  input  logic [WORD_W-1:0] inB,
  input  expWidthT          curE,
  input  strobeT            strobe,
  output logic              rangeErr,
  output logic              canNarrow,
  output logic [WORD_W-1:0] resWord,
  output logic              resSat
);

  logic [WORD_W-1:0] laneIn   [LANES];
  logic [WORD_W-1:0] opWord   [LANES];
  logic [WORD_W-1:0] wideWord [LANES];
  logic [WORD_W-1:0] prodWord;
  logic              prodSign;
  logic              ovf;
  logic              unf;
  logic              fitsNarrow;

  assign laneIn[0] = inA;
  assign laneIn[1] = inB;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    remul_reencode u_reenc (
      .word    (opWord[g]),
      .curE    (curE),
      .wideWord(wideWord[g])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              opWord[g] <= '0;
      else if (strobe.load)   opWord[g] <= laneIn[g];
      else if (strobe.retry)  opWord[g] <= wideWord[g];
    end
  end

  remul_mulcore u_core (
    .wordA     (opWord[0]),
    .wordB     (opWord[1]),
    .curE      (curE),
    .prodWord  (prodWord),
    .prodSign  (prodSign),
    .ovf       (ovf),
    .unf       (unf),
    .fitsNarrow(fitsNarrow)
  );

  assign rangeErr  = ovf | unf;
  assign canNarrow = fitsNarrow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resWord <= '0;
      resSat  <= 1'b0;
    end else if (strobe.finish) begin
      resSat <= ovf;
      if (ovf)      resWord <= {prodSign, {BODY_W{1'b1}}};
      else if (unf) resWord <= {prodSign, BODY_W'(0)};
      else          resWord <= prodWord;
    end
  end

endmodule

// File: rtl/remul_control.sv
// Sequencing, exponent-width register, handshake and retry counter.
module remul_control
  import remul_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             rangeErr,
  input  logic             canNarrow,
  output strobeT           strobe,
  output expWidthT         curE,
  output logic             inReady,
  output logic             outValid,
  output expWidthT         outExpW,
  output logic [CNT_W-1:0] retryCount
);

  typedef enum logic [0:0] {S_IDLE, S_CALC} stateT;

  stateT state;

  always_comb begin
    inReady       = (state == S_IDLE);
    strobe.load   = inValid && inReady;
    strobe.retry  = (state == S_CALC) && rangeErr && (int'(curE) < E_MAX);
    strobe.finish = (state == S_CALC) && !strobe.retry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      curE       <= EW'(E_RST);
      outValid   <= 1'b0;
      outExpW    <= EW'(E_RST);
      retryCount <= '0;
    end else begin
      outValid <= strobe.finish;
      if (strobe.load)   state <= S_CALC;
      if (strobe.finish) state <= S_IDLE;
      if (strobe.retry) begin
        curE <= curE + EW'(1);
        if (retryCount != {CNT_W{1'b1}}) retryCount <= retryCount + CNT_W'(1);
      end
      if (strobe.finish) begin
        outExpW <= curE;
        if (canNarrow) curE <= curE - EW'(1);
      end
    end
  end

endmodule

// File: rtl/remul_unit.sv
module remul_unit
  import remul_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [WORD_W-1:0] inA,
  input  logic [WORD_W-1:0] inB,
  output logic             outValid,
  output logic [WORD_W-1:0] outWord,
  output logic [EW-1:0]    outExpW,
  output logic             outSat,
  output logic [CNT_W-1:0] retryCount
);

  strobeT   strobe;
  expWidthT curE;
  logic     rangeErr;
  logic     canNarrow;

  remul_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .rangeErr  (rangeErr),
    .canNarrow (canNarrow),
    .strobe    (strobe),
    .curE      (curE),
    .inReady   (inReady),
    .outValid  (outValid),
    .outExpW   (outExpW),
    .retryCount(retryCount)
  );

  remul_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inA      (inA),
    .inB      (inB),
    .curE     (curE),
    .strobe   (strobe),
    .rangeErr (rangeErr),
    .canNarrow(canNarrow),
    .resWord  (outWord),
    .resSat   (outSat)
  );

endmodule

// File: rtl/remul_unit_chk.sv
module remul_unit_chk
  import remul_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic [WORD_W-1:0] outWord,
  input logic [EW-1:0]    outExpW,
  input logic             outSat,
  input logic [CNT_W-1:0] retryCount
);

  // R1: reported width stays inside its bounds
  p_width_bounds_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'(outExpW) >= E_MIN && int'(outExpW) <= E_MAX));

  // R4: saturation only at the widest format and as the largest magnitude
  p_sat_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSat) |-> (int'(outExpW) == E_MAX && outWord[BODY_W-1:0] == {BODY_W{1'b1}}));

  // R7: a result is delivered only as the unit returns to idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inReady);

  // R7: accepting a pair makes the unit busy in the next cycle
  p_busy_after_take_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R7: one pulse per product
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R3: retries only happen while busy
  p_retry_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> $stable(retryCount));

  // R8: the counter moves by at most one per cycle
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (retryCount == $past(retryCount) || retryCount == $past(retryCount) + CNT_W'(1)));

  // R8: the counter holds at its ceiling
  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retryCount == {CNT_W{1'b1}}) |=> (retryCount == {CNT_W{1'b1}}));

endmodule

bind remul_unit remul_unit_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .outValid  (outValid),
  .outWord   (outWord),
  .outExpW   (outExpW),
  .outSat    (outSat),
  .retryCount(retryCount)
);

// File: tb/remul_unit_tb_top.sv
`timescale 1ns/1ps
module remul_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic        inReady;
  logic [15:0] inA;
  logic [15:0] inB;
  logic        outValid;
  logic [15:0] outWord;
  logic [3:0]  outExpW;
  logic        outSat;
  logic [15:0] retryCount;

  always #10 clk = ~clk;

  remul_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inA(inA), .inB(inB), .outValid(outValid), .outWord(outWord),
    .outExpW(outExpW), .outSat(outSat), .retryCount(retryCount)
  );

  typedef struct {
    logic [15:0] word;
    int          e;
    bit          sat;
    int          cnt;
    string       tag;
  } expT;

  expT sb[$];
  int  nChecks = 0;
  int  nBad    = 0;
  int  mE      = 5;
  int  mCnt    = 0;
  bit  finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int biasE(input int e);
    return (1 << (e - 1)) - 1;
  endfunction

  function automatic logic [15:0] mkw(input bit s, input int u, input int mant, input int e);
    int mw;
    mw = 15 - e;
    return {s, 15'(((u + biasE(e)) << mw) | mant)};
  endfunction

  // operand in width e -> width e+1, dropping one fraction bit (ties to even)
  function automatic logic [15:0] reenc(input logic [15:0] w, input int e);
    int     mw, field, u;
    longint sig, q;
    mw    = 15 - e;
    field = int'(w[14:0] >> mw) & ((1 << e) - 1);
    if (field == 0) return {w[15], 15'd0};
    sig = (longint'(1) << mw) | longint'(w[14:0] & 15'((1 << mw) - 1));
    u   = field - biasE(e);
    q   = sig >> 1;
    if ((sig & 1) != 0 && (q & 1) != 0) q++;
    if (q == (longint'(1) << mw)) begin q = q >> 1; u++; end
    return mkw(w[15], u, int'(q - (longint'(1) << (mw - 1))), e + 1);
  endfunction

  task automatic modelOp(input logic [15:0] a0, input logic [15:0] b0,
                         output expT x, output int retries);
    logic [15:0] a, b, w;
    bit     done, zr, sgn, sat, narrow;
    int     mw, fa, fb, u, fieldR;
    longint sa, sb2, s, q, r, half;
    int     sh;
    a = a0; b = b0; done = 0; retries = 0;
    zr = 0; sgn = 0; u = 0; fieldR = 1; q = 0; mw = 0;
    while (!done) begin
      mw  = 15 - mE;
      fa  = int'(a[14:0] >> mw) & ((1 << mE) - 1);
      fb  = int'(b[14:0] >> mw) & ((1 << mE) - 1);
      sgn = a[15] ^ b[15];
      zr  = (fa == 0) || (fb == 0);
      if (zr) begin
        done = 1;
      end else begin
        sa  = (longint'(1) << mw) | longint'(a[14:0] & 15'((1 << mw) - 1));
        sb2 = (longint'(1) << mw) | longint'(b[14:0] & 15'((1 << mw) - 1));
        s   = sa * sb2;
        u   = (fa - biasE(mE)) + (fb - biasE(mE));
        if (s >= (longint'(1) << (2 * mw + 1))) begin sh = mw + 1; u++; end
        else sh = mw;
        q    = s >> sh;
        r    = s - (q << sh);
        half = longint'(1) << (sh - 1);
        if (r > half || (r == half && (q & 1) != 0)) q++;
        if (q == (longint'(1) << (mw + 1))) begin q = q >> 1; u++; end
        fieldR = u + biasE(mE);
        if ((fieldR > (1 << mE) - 1 || fieldR < 1) && mE < 8) begin
          a = reenc(a, mE);
          b = reenc(b, mE);
          mE++;
          if (mCnt < 65535) mCnt++;
          retries++;
        end else done = 1;
      end
    end
    sat = 0; narrow = 0;
    if (zr)                           w = {sgn, 15'd0};
    else if (fieldR > (1 << mE) - 1) begin w = {sgn, 15'h7FFF}; sat = 1; end
    else if (fieldR < 1)             w = {sgn, 15'd0};
    else begin
      w = mkw(sgn, u, int'(q - (longint'(1) << mw)), mE);
      narrow = (mE > 3) && (u >= 2 - (1 << (mE - 2))) && (u <= (1 << (mE - 2)));
    end
    x.word = w; x.e = mE; x.sat = sat; x.cnt = mCnt; x.tag = "";
    if (narrow) mE--;
  endtask

  // called at a negedge with the unit idle; returns at the negedge of the result
  task automatic issue(input logic [15:0] a, input logic [15:0] b, input string tag, input bit junk);
    expT x;
    int  retries, lat;
    chk({tag, " R7 ready when idle"}, inReady, 1);
    inA = a; inB = b; inValid = 1'b1;
    modelOp(a, b, x, retries);
    x.tag = tag;
    sb.push_back(x);
    @(negedge clk);
    if (junk) begin inA = 16'($urandom); inB = 16'($urandom); end
    else inValid = 1'b0;
    chk({tag, " R7 busy after accept"}, inReady, 0);
    lat = 1;
    while (!outValid && lat < 40) begin
      @(negedge clk);
      lat++;
      if (junk) begin inA = 16'($urandom); inB = 16'($urandom); end
    end
    inValid = 1'b0;
    chk({tag, " R3 R7 latency"}, lat, 2 + retries);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN === 1'b1 && outValid === 1'b1) begin
      if (sb.size() == 0) chk("R7 unexpected result", 1, 0);
      else begin
        expT x;
        x = sb.pop_front();
        chk({x.tag, " word"}, outWord, x.word);
        chk({x.tag, " R1 width"}, outExpW, x.e);
        chk({x.tag, " R4 sat flag"}, outSat, x.sat);
        chk({x.tag, " R8 retry count"}, retryCount, x.cnt);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nBad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    inValid = 1'b0; inA = '0; inB = '0; rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 ready after reset", inReady, 1);
    chk("R9 no output after reset", outValid, 0);
    chk("R9 counter cleared", retryCount, 0);

    issue(mkw(0, 0, 0, mE), mkw(0, 0, 0, mE), "R9 R2 R5 unity at reset width", 0);
    issue(mkw(0, 1, (1 << (15 - mE)) - 1, mE), mkw(1, 0, 5, mE), "R2 rounding", 0);
    issue({1'b1, 15'd0}, mkw(0, 1, 3, mE), "R6 zero operand", 0);
    issue(mkw(0, 0, 1, mE), mkw(0, 0, 3, mE), "R6 R5 width after zero", 0);
    for (int i = 0; i < 6; i++) issue(mkw(0, 0, 0, mE), mkw(1, 0, 0, mE), "R5 narrowing", 0);
    for (int i = 0; i < 8 && mE < 8; i++)
      issue(mkw(0, 1 << (mE - 1), 3, mE), mkw(1, 1 << (mE - 1), 1, mE), "R3 overflow retry", 0);
    issue(mkw(1, 128, 5, 8), mkw(0, 128, 0, 8), "R4 saturate", 0);
    issue(mkw(0, -126, 7, 8), mkw(1, -126, 2, 8), "R4 flush", 0);
    for (int i = 0; i < 6; i++) issue(mkw(0, 0, 0, mE), mkw(0, 0, 0, mE), "R5 narrowing", 0);
    for (int i = 0; i < 8 && mE < 8; i++)
      issue(mkw(0, 2 - (1 << (mE - 1)), 1, mE), mkw(0, 2 - (1 << (mE - 1)), 3, mE),
            "R3 underflow retry", 0);
    issue(mkw(0, 1, 9, mE), mkw(1, 2, 6, mE), "R7 busy inputs ignored", 1);
    for (int i = 0; i < 400; i++)
      issue(16'($urandom), 16'($urandom), "R1 R2 random", 1'($urandom));
    @(negedge clk);
    @(negedge clk);
    chk("R7 all results delivered", sb.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule